// File: doc/BRIEF.md
# Iterative RC6 Encryption Core

This block encrypts 128-bit blocks with the RC6 block cipher. The word size is 32 bits and the core runs 20 rounds. The round keys are already expanded and are loaded from outside, one word per clock, together with an index. The keys sit in two internal single-port memories. One memory holds the keys with even indices and the other holds the keys with odd indices. A round therefore fetches both of its keys in the same cycle.

After the keys are loaded, a plaintext block is presented with a strobe and encryption starts at once. The core makes one whitening pass on B and D. It then runs one round per clock and ends with one whitening pass on A and C. It then pulses a completion flag for one cycle and places the ciphertext on a registered output. That output holds its value until the next block completes. Key expansion and decryption are left to other logic.

Top module: `rc6_encrypt_core`

## Requirements
- R1: A synchronous active-high reset sets `done` to 0 and `ct_out` to zero, and returns the core to idle. A block that is being encrypted when reset arrives is abandoned.
- R2: A key is written on a rising edge where `key_wr` is 1, storing `key_data` as key S[j] with j = `key_idx`. Bit 0 of `key_idx` selects the bank (0 for even keys, 1 for odd keys), and bits [5:1] select the slot. A write with an index of 44 or more has no effect.
- R3: On a rising edge where `blk_wr` is 1 and the core is idle, the block is captured with A = `blk_in[127:96]`, B = `blk_in[95:64]`, C = `blk_in[63:32]` and D = `blk_in[31:0]`.
- R4: The first step after capture adds S[0] to B and S[1] to D, both modulo 2^32.
- R5: Round i (1..20) computes T = rotl(B*(2B+1), 5) and U = rotl(D*(2D+1), 5). It then computes A' = rotl(A xor T, U) + S[2i] and C' = rotl(C xor U, T) + S[2i+1], and loads (A,B,C,D) with (B,C',D,A').
- R6: The last step adds S[42] to A and S[43] to C. The ciphertext appears on `ct_out` as {A,B,C,D}, with A in the most significant word.
- R7: `done` rises exactly 22 rising edges after the capture edge, and `ct_out` changes at that same edge.
- R8: `done` is high for exactly one cycle per block. A block presented in the cycle right after `done` is accepted, so blocks can run back to back, each one 23 cycles after the one before.
- R9: `ct_out` holds its value except at a completion edge. It reads zero until the first completion after reset.
- R10: A `blk_wr` that arrives while a block is being encrypted, including the final cycle, is ignored. Neither the running result nor its timing changes.
- R11: A variable rotation uses only bits [4:0] of its amount, so the rotation distance is between 0 and 31.
- R12: Reset leaves the key memories intact. A block encrypted after reset, without reloading the keys, uses the keys loaded earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_wr | input | 1 | Key write strobe |
| key_idx | input | 6 | Index j of the key being written |
| key_data | input | 32 | Key word S[j] |
| blk_wr | input | 1 | Plaintext capture strobe |
| blk_in | input | 128 | Plaintext block {A,B,C,D} |
| done | output | 1 | One-cycle completion pulse |
| ct_out | output | 128 | Registered ciphertext {A,B,C,D} |

## Verification
The corner cases are the exact latency of 22 edges, the zero output before the first block, and blocks held back to back by a strobe that stays high. A design that is off by one cycle, or that fetches keys one slot late, fails the comparison made on every clock. A second strobe in the middle of a block must be ignored. A core that restarted on it would show a late `done` and the wrong ciphertext. Keys are loaded from the highest index down, and indices outside the key range are then written with junk. A bank selected by the wrong bit, or an address that wraps, would corrupt the results. A reset in the middle of a block must clear the output but keep the keys, so a core that cleared its memories would produce a different ciphertext for the block that follows.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_RUN  = 2'd2,
    PH_POST = 2'd3
  } rc6_phase_e;
endpackage

// File: rtl/rc6_key_bank.sv
// One bank of round keys: a single shared address port, so a write takes
// the port for its cycle and a read returns data one cycle after its address.
module rc6_key_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 22,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] port_addr;

  assign port_addr = wr_en ? wr_addr : rd_addr;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[port_addr] <= wr_data;
    end else if (rd_en) begin
      rd_data <= mem[port_addr];
    end
  end
endmodule

// File: rtl/rc6_round.sv
// Combinational RC6 round: quadratic mix, data-dependent rotations, key add.
module rc6_round #(
  parameter int WORD_W = 32,
  parameter int LGW    = 5
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] c_i,
  input  logic [WORD_W-1:0] d_i,
  input  logic [WORD_W-1:0] k_even,
  input  logic [WORD_W-1:0] k_odd,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic [WORD_W-1:0] c_o,
  output logic [WORD_W-1:0] d_o
);
  localparam logic [LGW-1:0] FIX_ROT = LGW'(LGW);

  // Rotate left by taking the upper half of a doubled word shifted left.
  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x,
                                             input logic [LGW-1:0]    n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << n;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  logic [WORD_W-1:0] b_odd, d_odd, b_sq, d_sq, t_mix, u_mix, a_new, c_new;

  assign b_odd = {b_i[WORD_W-2:0], 1'b1};
  assign d_odd = {d_i[WORD_W-2:0], 1'b1};
  assign b_sq  = b_i * b_odd;
  assign d_sq  = d_i * d_odd;
  assign t_mix = rotl(b_sq, FIX_ROT);
  assign u_mix = rotl(d_sq, FIX_ROT);
  // Only the low LGW bits of the mixed words steer the rotations.
  assign a_new = rotl(a_i ^ t_mix, u_mix[LGW-1:0]) + k_even;
  assign c_new = rotl(c_i ^ u_mix, t_mix[LGW-1:0]) + k_odd;

  assign a_o = b_i;
  assign b_o = c_new;
  assign c_o = d_i;
  assign d_o = a_new;
endmodule

// File: rtl/rc6_ctrl.sv
// Phase sequencer and key-pair counter. The pair address is issued one
// cycle ahead of use to cover the synchronous read of the key banks.
module rc6_ctrl
  import rc6_pkg::*;
#(
  parameter int ROUNDS = 20,
  parameter int PAIR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_wr,
  output rc6_phase_e        phase,
  output logic              ld_blk,
  output logic              rd_en,
  output logic [PAIR_W-1:0] rd_pair,
  output logic              done
);
  localparam logic [PAIR_W-1:0] LAST_RND = PAIR_W'(ROUNDS);
  localparam logic [PAIR_W-1:0] ONE      = PAIR_W'(1);

  logic [PAIR_W-1:0] pair_q;

  assign ld_blk = (phase == PH_IDLE) && blk_wr;

  always_comb begin
    rd_en   = 1'b1;
    rd_pair = '0;
    case (phase)
      PH_IDLE: begin
        rd_en   = blk_wr;
        rd_pair = '0;
      end
      PH_PRE:  rd_pair = ONE;
      PH_RUN:  rd_pair = pair_q + ONE;
      default: begin
        rd_en   = 1'b0;
        rd_pair = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      pair_q <= '0;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      pair_q <= rd_pair;
      case (phase)
        PH_IDLE: if (blk_wr) phase <= PH_PRE;
        PH_PRE:  phase <= PH_RUN;
        PH_RUN:  if (pair_q == LAST_RND) phase <= PH_POST;
        default: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/rc6_encrypt_core.sv
module rc6_encrypt_core
  import rc6_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 20,
  localparam int KEY_CNT = 2 * ROUNDS + 4,
  localparam int IDX_W   = $clog2(KEY_CNT),
  localparam int BLK_W   = 4 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] key_data,
  input  logic              blk_wr,
  input  logic [BLK_W-1:0]  blk_in,
  output logic              done,
  output logic [BLK_W-1:0]  ct_out
);
  localparam int BANK_D = ROUNDS + 2;
  localparam int PAIR_W = $clog2(BANK_D);
  localparam int LGW    = $clog2(WORD_W);
  localparam logic [IDX_W:0] KEY_LIMIT = (IDX_W + 1)'(KEY_CNT);

  rc6_phase_e        phase;
  logic              ld_blk, rd_en, key_ok;
  logic [PAIR_W-1:0] rd_pair;
  logic [WORD_W-1:0] bank_q [2];
  logic [WORD_W-1:0] wa, wb, wc, wd;
  logic [WORD_W-1:0] ra, rb, rc, rd;

  assign key_ok = ({1'b0, key_idx} < KEY_LIMIT);

  rc6_ctrl #(.ROUNDS(ROUNDS), .PAIR_W(PAIR_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .blk_wr (blk_wr),
    .phase  (phase),
    .ld_blk (ld_blk),
    .rd_en  (rd_en),
    .rd_pair(rd_pair),
    .done   (done)
  );

  // Bank 0 holds even-indexed keys, bank 1 odd-indexed keys.
  for (genvar p = 0; p < 2; p++) begin : g_bank
    rc6_key_bank #(.WORD_W(WORD_W), .DEPTH(BANK_D), .ADDR_W(PAIR_W)) u_bank (
      .clk    (clk),
      .wr_en  (key_wr && key_ok && (key_idx[0] == 1'(p))),
      .wr_addr(key_idx[IDX_W-1:1]),
      .wr_data(key_data),
      .rd_en  (rd_en),
      .rd_addr(rd_pair),
      .rd_data(bank_q[p])
    );
  end

  rc6_round #(.WORD_W(WORD_W), .LGW(LGW)) u_round (
    .a_i   (wa),
    .b_i   (wb),
    .c_i   (wc),
    .d_i   (wd),
    .k_even(bank_q[0]),
    .k_odd (bank_q[1]),
    .a_o   (ra),
    .b_o   (rb),
    .c_o   (rc),
    .d_o   (rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wa     <= '0;
      wb     <= '0;
      wc     <= '0;
      wd     <= '0;
      ct_out <= '0;
    end else if (ld_blk) begin
      wa <= blk_in[4*WORD_W-1 -: WORD_W];
      wb <= blk_in[3*WORD_W-1 -: WORD_W];
      wc <= blk_in[2*WORD_W-1 -: WORD_W];
      wd <= blk_in[WORD_W-1 -: WORD_W];
    end else begin
      case (phase)
        PH_PRE: begin
          wb <= wb + bank_q[0];
          wd <= wd + bank_q[1];
        end
        PH_RUN: begin
          wa <= ra;
          wb <= rb;
          wc <= rc;
          wd <= rd;
        end
        PH_POST: ct_out <= {wa + bank_q[0], wb, wc + bank_q[1], wd};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rc6_core_chk.sv
module rc6_core_chk #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                blk_wr,
  input logic                done,
  input logic [4*WORD_W-1:0] ct_out
);
  localparam int LAT = ROUNDS + 2;
  localparam int CW  = $clog2(LAT + 1);

  logic          busy, exp_done, seen_done;
  logic [CW-1:0] cnt;

  // Independent latency tracker started by an accepted strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      exp_done  <= 1'b0;
      seen_done <= 1'b0;
    end else begin
      exp_done <= 1'b0;
      if (done) seen_done <= 1'b1;
      if (busy) begin
        if (cnt == CW'(LAT - 1)) begin
          busy     <= 1'b0;
          exp_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (blk_wr) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (rst)
    exp_done |-> done);  // R7
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> exp_done);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8
  AST_ZERO_BEFORE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!seen_done && !done) |-> (ct_out == '0));  // R9
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!rst)) |-> $stable(ct_out));  // R9
endmodule

bind rc6_encrypt_core rc6_core_chk #(.WORD_W(WORD_W), .ROUNDS(ROUNDS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .blk_wr(blk_wr),
  .done  (done),
  .ct_out(ct_out)
);

// File: tb/test_rc6_encrypt_core.sv
module test_rc6_encrypt_core;
  localparam int W   = 32;
  localparam int R   = 20;
  localparam int NK  = 2 * R + 4;
  localparam int IW  = $clog2(NK);
  localparam int LAT = R + 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           key_wr = 1'b0;
  logic [IW-1:0]  key_idx = '0;
  logic [W-1:0]   key_data = '0;
  logic           blk_wr = 1'b0;
  logic [4*W-1:0] blk_in = '0;
  logic           done;
  logic [4*W-1:0] ct_out;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rc6_encrypt_core #(.WORD_W(W), .ROUNDS(R)) i_rc6_encrypt_core (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_idx(key_idx),
    .key_data(key_data), .blk_wr(blk_wr), .blk_in(blk_in),
    .done(done), .ct_out(ct_out)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [4*W-1:0] act, input logic [4*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural cipher model.
  logic [W-1:0] skey [NK];

  function automatic logic [W-1:0] rotl32(input logic [W-1:0] x, input int n);
    int s;
    s = n & 31;  // R11: low five bits only
    if (s == 0) return x;
    return (x << s) | (x >> (32 - s));
  endfunction

  function automatic logic [4*W-1:0] ref_enc(input logic [4*W-1:0] blk);
    logic [W-1:0] a, b, c, d, t, u, an, cn, sq;
    a = blk[127:96]; b = blk[95:64]; c = blk[63:32]; d = blk[31:0];
    b = b + skey[0];
    d = d + skey[1];
    for (int i = 1; i <= R; i++) begin
      sq = b * (b + b + 1); t = rotl32(sq, 5);
      sq = d * (d + d + 1); u = rotl32(sq, 5);
      an = rotl32(a ^ t, int'(u)) + skey[2*i];
      cn = rotl32(c ^ u, int'(t)) + skey[2*i+1];
      a = b; b = cn; c = d; d = an;
    end
    a = a + skey[2*R+2];
    c = c + skey[2*R+3];
    return {a, b, c, d};
  endfunction

  // Cycle model: tracks busy window, expected done and held output.
  logic           m_busy = 1'b0;
  int             m_cnt = 0;
  logic [4*W-1:0] m_res = '0;
  logic           exp_done = 1'b0;
  logic [4*W-1:0] exp_ct = '0;

  always @(posedge clk) begin
    if (key_wr && int'(key_idx) < NK) skey[key_idx] <= key_data;
    if (rst) begin
      m_busy <= 1'b0; m_cnt <= 0; exp_done <= 1'b0; exp_ct <= '0;
    end else begin
      exp_done <= 1'b0;
      if (m_busy) begin
        if (m_cnt == LAT - 1) begin
          m_busy <= 1'b0; exp_done <= 1'b1; exp_ct <= m_res;
        end else m_cnt <= m_cnt + 1;
      end else if (blk_wr) begin
        m_busy <= 1'b1; m_cnt <= 0; m_res <= ref_enc(blk_in);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(done == exp_done, "R8 done per-cycle", 128'(done), 128'(exp_done));
      check(ct_out == exp_ct, "R9 ct_out per-cycle", ct_out, exp_ct);
    end
  end

  task automatic run_block(input logic [4*W-1:0] blk, input string tag);
    logic [4*W-1:0] expv;
    int cyc;
    expv = ref_enc(blk);
    blk_wr = 1'b1; blk_in = blk;
    @(negedge clk);
    blk_wr = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == LAT + 1, {tag, " R7 latency"}, 128'(cyc), 128'(LAT + 1));
    check(ct_out == expv, tag, ct_out, expv);
    @(negedge clk);
  endtask

  initial begin
    logic [4*W-1:0] x_blk, y_blk;
    int dones;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 128'(done), 128'(0));
    check(ct_out == '0, "R1 ct_out in reset", ct_out, '0);
    rst = 1'b0;
    @(negedge clk);

    // R2: load keys from highest index down, then junk out of range.
    for (int j = NK - 1; j >= 0; j--) begin
      key_wr = 1'b1; key_idx = IW'(j);
      key_data = (32'(j) + 32'd1) * 32'h9E37_79B9 ^ {16'(j), 16'hC3A5};
      @(negedge clk);
    end
    for (int j = NK; j < (1 << IW); j++) begin
      key_wr = 1'b1; key_idx = IW'(j); key_data = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    key_wr = 1'b0;
    check(ct_out == '0, "R9 zero before first block", ct_out, '0);

    run_block('0, "R4 R5 zero block");
    run_block('1, "R5 ones block");
    run_block(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, "R3 R6 word order");
    run_block(128'hFFFF_FFE0_8000_001F_7FFF_FFFF_0000_0021, "R11 rotation amounts");
    run_block(128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321, "R2 bank mapping");

    // R10: second strobe mid-block must be ignored.
    x_blk = 128'hCAFE_F00D_0BAD_BEEF_1357_9BDF_2468_ACE0;
    y_blk = 128'h5555_AAAA_3333_CCCC_0F0F_F0F0_00FF_FF00;
    blk_wr = 1'b1; blk_in = x_blk;
    @(negedge clk);
    blk_wr = 1'b0;
    repeat (4) @(negedge clk);
    blk_wr = 1'b1; blk_in = y_blk;
    @(negedge clk);
    blk_wr = 1'b0;
    repeat (LAT - 5) @(negedge clk);
    check(done == 1'b1, "R10 done timing kept", 128'(done), 128'(1));
    check(ct_out == ref_enc(x_blk), "R10 result of first block", ct_out, ref_enc(x_blk));
    @(negedge clk);

    // R8: strobe held high, three back-to-back blocks.
    dones = 0;
    blk_wr = 1'b1; blk_in = 128'h0BAD_0001_0BAD_0002_0BAD_0003_0BAD_0004;
    for (int k = 1; k <= 3 * (LAT + 1); k++) begin
      @(negedge clk);
      if (done) dones++;
      blk_in = {32'(k), 32'hA5A5_0000 + 32'(k), ~32'(k), 32'(k * 7)};
    end
    blk_wr = 1'b0;
    check(dones == 3, "R8 back-to-back pulses", 128'(dones), 128'(3));
    repeat (2) @(negedge clk);

    // R1/R12: reset mid-block keeps keys.
    blk_wr = 1'b1; blk_in = x_blk;
    @(negedge clk);
    blk_wr = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ct_out == '0, "R1 ct_out after mid-block reset", ct_out, '0);
    check(done == 1'b0, "R1 done after mid-block reset", 128'(done), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    run_block(y_blk, "R12 keys kept over reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule